// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address of a memory operand for a two-operand instruction. The destination operand is also the first source. Each request carries a base register value, an index register value, a 2-bit scale, a displacement with a size code, and an addressing-mode selector. The block adds the selected terms with wrap-around arithmetic and registers the sum. The address comes out one clock after the request, together with a valid flag.

Each request also carries the operand kinds of the destination and the second source. The block checks this pairing. Memory-to-memory and immediate-to-immediate pairings are rejected, as is any pairing with an immediate or reserved destination. A rejected request raises an illegal-operand flag and does not mark the address valid. Segmentation, paging, protection and the memory access itself are handled elsewhere.

Top module: `scaled_addr_gen`

## Requirements
- R1: In mode 0 (register indirect), the address equals the base value.
- R2: In mode 1 (base plus displacement), the address equals base plus the sign-extended displacement.
- R3: Mode 2 gives base + (index << scale). Mode 3 gives base + (index << scale) + the sign-extended displacement. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R4: The displacement size code selects the width. Code 0 takes bits 7:0 and sign-extends them. Code 1 takes bits 15:0 and sign-extends them. Codes 2 and 3 take all 32 bits.
- R5: All additions wrap modulo 2^32. No carry or overflow indication is produced.
- R6: Operand kinds are encoded as 0 = register, 1 = immediate, 2 = memory and 3 = reserved. Five destination/source pairings are legal:
  - register/register
  - register/immediate
  - register/memory
  - memory/register
  - memory/immediate
- R7: An accepted request with any other pairing raises illegalOp one clock later, with outValid low. outValid and illegalOp are never high together.
- R8: A request is accepted on a clock edge where reqValid is high. outValid, illegalOp and effAddr update exactly one clock later. After a cycle with reqValid low, outValid and illegalOp are low and effAddr holds its value.
- R9: A synchronous active-high reset clears outValid, illegalOp and effAddr.
- R10: The index and scale inputs have no effect in modes 0 and 1. The displacement inputs have no effect in modes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| modeSel | input | 2 | Addressing mode (0..3, see R1-R3) |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| scaleSel | input | 2 | Index shift amount (0..3) |
| dispVal | input | 32 | Displacement, low bits used per size code |
| dispSize | input | 2 | Displacement size code |
| dstKind | input | 2 | Destination operand kind |
| srcKind | input | 2 | Second source operand kind |
| outValid | output | 1 | effAddr holds a legal result |
| illegalOp | output | 1 | The last request had an illegal pairing |
| effAddr | output | 32 | Registered effective address |

## Verification
The block's state is only its output register. A wrong decode or a wrong extension therefore shows as a wrong effAddr on the very next clock after the request. A wrong legality decision shows as outValid or illegalOp taking the wrong value in that same cycle. A stale load, where the register is written with no request, shows one cycle later as effAddr changing on an idle cycle. The sweeps cover every combination of mode, scale and size code, as well as all sixteen operand pairings. Each result is compared one cycle after its request.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    MODE_REGIND   = 2'd0,
    MODE_BASEDISP = 2'd1,
    MODE_IDX      = 2'd2,
    MODE_IDXDISP  = 2'd3
  } sagMode_e;

  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_IMM = 2'd1,
    KIND_MEM = 2'd2,
    KIND_RSV = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    DSZ_8  = 2'd0,
    DSZ_16 = 2'd1,
    DSZ_32 = 2'd2,
    DSZ_32B = 2'd3
  } dispSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic useIndex;
    logic useDisp;
  } sagStrobe_t;
endpackage

// File: rtl/sag_ctrl.sv
module sag_ctrl
  import sag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] modeSel,
  input  logic [1:0] dstKind,
  input  logic [1:0] srcKind,
  output sagStrobe_t strobe,
  output logic       outValid,
  output logic       illegalOp
);
  logic pairLegal;

  // Legal destination/source pairings (R6)
  always_comb begin
    pairLegal = 1'b0;
    unique case (opKind_e'(dstKind))
      KIND_REG: pairLegal = (srcKind != KIND_RSV);
      KIND_MEM: pairLegal = (srcKind == KIND_REG) || (srcKind == KIND_IMM);
      default:  pairLegal = 1'b0;
    endcase
  end

  // Mode decode into strobes (R1-R3, R10)
  always_comb begin
    strobe.load     = reqValid;
    strobe.useIndex = 1'b0;
    strobe.useDisp  = 1'b0;
    unique case (sagMode_e'(modeSel))
      MODE_REGIND:   begin strobe.useIndex = 1'b0; strobe.useDisp = 1'b0; end
      MODE_BASEDISP: begin strobe.useIndex = 1'b0; strobe.useDisp = 1'b1; end
      MODE_IDX:      begin strobe.useIndex = 1'b1; strobe.useDisp = 1'b0; end
      MODE_IDXDISP:  begin strobe.useIndex = 1'b1; strobe.useDisp = 1'b1; end
      default:       begin strobe.useIndex = 1'b0; strobe.useDisp = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= reqValid && pairLegal;
      illegalOp <= reqValid && !pairLegal;
    end
  end

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(outValid && illegalOp));

  assert_memmem_illegal_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && ((dstKind == KIND_MEM && srcKind == KIND_MEM) ||
                  (dstKind == KIND_IMM && srcKind == KIND_IMM)))
    |=> (illegalOp && !outValid));

  assert_regreg_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && dstKind == KIND_REG && srcKind == KIND_REG) |=> outValid);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!outValid && !illegalOp));
endmodule

// File: rtl/sag_datapath.sv
module sag_datapath
  import sag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  sagStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic [1:0]         dispSize,
  output logic [ADDR_W-1:0]  effAddr
);
  localparam int NUM_SCALES = 1 << SCALE_W;

  logic [ADDR_W-1:0] shiftOpt [NUM_SCALES];
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] idxTerm;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] sumNext;

  // One pre-shifted index per scale code (R3)
  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_shift
    assign shiftOpt[s] = indexVal << s;
  end

  // Displacement sign extension (R4)
  always_comb begin
    unique case (dispSize_e'(dispSize))
      DSZ_8:   dispExt = {{(ADDR_W-8){dispVal[7]}}, dispVal[7:0]};
      DSZ_16:  dispExt = {{(ADDR_W-16){dispVal[15]}}, dispVal[15:0]};
      default: dispExt = dispVal;
    endcase
  end

  assign idxTerm  = strobe.useIndex ? shiftOpt[scaleSel] : '0;
  assign dispTerm = strobe.useDisp  ? dispExt : '0;
  assign sumNext  = baseVal + idxTerm + dispTerm;   // wraps (R5)

  always_ff @(posedge clk) begin
    if (rst)              effAddr <= '0;
    else if (strobe.load) effAddr <= sumNext;
  end

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(effAddr));

  assert_regind_base_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.useIndex && !strobe.useDisp)
    |=> (effAddr == $past(baseVal)));

  assert_unit_index_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.useIndex && !strobe.useDisp && indexVal == ADDR_W'(1))
    |=> (effAddr == $past(baseVal) + (ADDR_W'(1) << $past(scaleSel))));
endmodule

// File: rtl/scaled_addr_gen.sv
module scaled_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [1:0]         modeSel,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic [1:0]         dispSize,
  input  logic [1:0]         dstKind,
  input  logic [1:0]         srcKind,
  output logic               outValid,
  output logic               illegalOp,
  output logic [ADDR_W-1:0]  effAddr
);
  sagStrobe_t strobe;

  sag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .modeSel(modeSel),
    .dstKind(dstKind), .srcKind(srcKind), .strobe(strobe),
    .outValid(outValid), .illegalOp(illegalOp)
  );

  sag_datapath #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .baseVal(baseVal),
    .indexVal(indexVal), .scaleSel(scaleSel), .dispVal(dispVal),
    .dispSize(dispSize), .effAddr(effAddr)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!outValid && !illegalOp && effAddr == '0));
endmodule

// File: tb/tb_scaled_addr_gen.sv
module tb_scaled_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [31:0] baseVal = '0, indexVal = '0, dispVal = '0;
  logic [1:0]  scaleSel = '0, dispSize = '0, dstKind = '0, srcKind = '0;
  logic        outValid, illegalOp;
  logic [31:0] effAddr;

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  scaled_addr_gen dut (.*);

  function automatic logic [31:0] nextRand(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic logic [31:0] sext(logic [31:0] d, logic [1:0] sz);
    case (sz)
      2'd0:    return {{24{d[7]}}, d[7:0]};
      2'd1:    return {{16{d[15]}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] model(logic [1:0] m, logic [31:0] b, logic [31:0] x,
                                        logic [1:0] s, logic [31:0] d, logic [1:0] sz);
    logic [63:0] acc;
    acc = {32'd0, b};
    if (m[1]) acc = acc + ({32'd0, x} * (64'd1 << s));
    if (m == 2'd1 || m == 2'd3) acc = acc + {32'd0, sext(d, sz)};
    return acc[31:0];   // modulo 2^32
  endfunction

  function automatic bit legalPair(logic [1:0] dk, logic [1:0] sk);
    if (dk == 2'd0) return sk != 2'd3;
    if (dk == 2'd2) return sk == 2'd0 || sk == 2'd1;
    return 1'b0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, capture at posedge, sample at following negedge
  task automatic issue(logic [1:0] m, logic [31:0] b, logic [31:0] x, logic [1:0] s,
                       logic [31:0] d, logic [1:0] sz, logic [1:0] dk, logic [1:0] sk);
    reqValid = 1'b1; modeSel = m; baseVal = b; indexVal = x; scaleSel = s;
    dispVal = d; dispSize = sz; dstKind = dk; srcKind = sk;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    // R9: reset with a live request
    reqValid = 1'b1; baseVal = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R9 outValid", {31'd0, outValid}, 32'd0);
    check("R9 illegalOp", {31'd0, illegalOp}, 32'd0);
    check("R9 effAddr", effAddr, 32'd0);
    reqValid = 1'b0; rst = 1'b0;
    @(negedge clk);

    // R1-R4: sweep of modes, scales and size codes
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int z = 0; z < 4; z++)
          for (int k = 0; k < 3; k++) begin
            logic [31:0] b, x, d;
            lfsr = nextRand(lfsr); b = lfsr;
            lfsr = nextRand(lfsr); x = lfsr;
            lfsr = nextRand(lfsr); d = lfsr;
            if (k == 1) d = {d[31:16], 1'b1, d[14:8], 1'b1, d[6:0]};   // negative small disp
            if (k == 2) d = {d[31:16], 1'b0, d[14:8], 1'b0, d[6:0]};   // positive small disp
            issue(2'(m), b, x, 2'(s), d, 2'(z), 2'd0, 2'd2);
            check(m == 0 ? "R1 regind" : m == 1 ? "R2/R4 basedisp" : "R3/R4 scaled",
                  effAddr, model(2'(m), b, x, 2'(s), d, 2'(z)));
            check("R8 outValid after legal req", {31'd0, outValid}, 32'd1);
          end

    // R5: wrap-around
    issue(2'd3, 32'hFFFF_FFF0, 32'h4000_0000, 2'd3, 32'h0000_0020, 2'd2, 2'd0, 2'd0);
    check("R5 wrap", effAddr, 32'h0000_0010);
    issue(2'd1, 32'h0000_0004, 32'd0, 2'd0, 32'h0000_0080, 2'd0, 2'd0, 2'd0);
    check("R5 wrap negative disp", effAddr, 32'hFFFF_FF84);

    // R10: ignored inputs do not change the result
    for (int i = 0; i < 8; i++) begin
      lfsr = nextRand(lfsr);
      issue(2'd0, 32'h1000_0000, lfsr, 2'(i), ~lfsr, 2'(i), 2'd2, 2'd1);
      check("R10 mode0 ignores index/scale/disp", effAddr, 32'h1000_0000);
      issue(2'd1, 32'h2000_0000, lfsr, 2'(i), 32'h0000_0010, 2'd2, 2'd2, 2'd1);
      check("R10 mode1 ignores index/scale", effAddr, 32'h2000_0010);
      issue(2'd2, 32'h3000_0000, 32'h10, 2'd1, lfsr, 2'(i), 2'd2, 2'd1);
      check("R10 mode2 ignores disp", effAddr, 32'h3000_0020);
    end

    // R6/R7: every operand pairing
    for (int dk = 0; dk < 4; dk++)
      for (int sk = 0; sk < 4; sk++) begin
        bit ok;
        ok = legalPair(2'(dk), 2'(sk));
        issue(2'd0, 32'h55AA_0000 + 32'(dk * 4 + sk), 32'd0, 2'd0, 32'd0, 2'd0, 2'(dk), 2'(sk));
        check("R6 outValid per pairing", {31'd0, outValid}, {31'd0, ok});
        check("R7 illegalOp per pairing", {31'd0, illegalOp}, {31'd0, !ok});
      end

    // R8: idle cycle clears flags and holds address
    issue(2'd1, 32'h0BAD_F00D, 32'd0, 2'd0, 32'h3, 2'd2, 2'd2, 2'd2);
    check("R7 memmem illegal", {31'd0, illegalOp}, 32'd1);
    @(negedge clk);
    check("R8 idle outValid", {31'd0, outValid}, 32'd0);
    check("R8 idle illegalOp", {31'd0, illegalOp}, 32'd0);
    check("R8 idle holds address", effAddr, 32'h0BAD_F010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule